// File: doc/BRIEF.md
# Configurable Mesh Route Compute Unit

This unit computes the output-port request of one switch in a two-dimensional on-chip mesh. It takes the switch's own coordinates and a packet's destination coordinates and compares them to find the direction of travel. Twelve configuration bits then shape the result. Four of them state which neighbour links exist. The other eight state which turns a packet may take at the next hop. With these bits, a mesh that has lost links or switches can still be routed deadlock-free without a per-destination table.

The configuration word is loaded through a write strobe at power-on and then frozen by a sticky lock. The result is a five-bit request vector over the four mesh ports and the local port. It is multi-hot when more than one productive port is allowed. An error flag is raised when a remote destination finds no usable port. A parameter can add a register stage after the route logic.

Top module: `mesh_route_unit`

## Requirements
- R1: Direction is decided by coordinate comparison, with y growing southward. North is productive when dstY < curY, south when dstY > curY, east when dstX > curX, and west when dstX < curX. A destination that differs in only one axis requests exactly the single productive port.
- R2: For a destination that differs in both axes, a mesh port is requested only if its turn bit for the other productive direction is set. The config word carries these bits at cfgData[11:4] in the order Rsw, Rse, Rws, Rwn, Res, Ren, Rnw, Rne (bit 11 down to bit 4). For example, north toward an east destination needs Rne at bit 4.
- R3: Each mesh port is gated by its link bit at cfgData[3:0]: bit 0 north, bit 1 east, bit 2 west, bit 3 south. A cleared link bit never lets that port be requested.
- R4: When the destination equals the current coordinates, only the local port is requested and every mesh port is low.
- R5: routeError is high exactly when the destination is remote and no mesh port is requested. The request vector is then all zero.
- R6: After reset the configuration word is 12'hFFF, which means all links are present and all turns are allowed.
- R7: A cycle with cfgWe high and the lock clear loads cfgData into the configuration at that clock edge.
- R8: A cycle with cfgLock high sets a lock that holds until reset. While locked, cfgWe has no effect on the configuration.
- R9: portReq encodes bit 0 north, bit 1 east, bit 2 west, bit 3 south and bit 4 local. With REG_OUT = 0 it is combinational from the coordinates and the stored configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgLock | input | 1 | Sets the sticky configuration lock |
| cfgData | input | 12 | Configuration word (links, turn bits) |
| curX | input | COORD_W | This switch's x coordinate |
| curY | input | COORD_W | This switch's y coordinate |
| dstX | input | COORD_W | Destination x coordinate |
| dstY | input | COORD_W | Destination y coordinate |
| portReq | output | 5 | Requested ports {L,S,W,E,N} |
| routeError | output | 1 | Remote destination with no usable port |

## Verification
On every cycle, the assertions check four things. A local request is exclusive. An error comes with an empty request. No absent link is ever requested, and a north request only points north. Once locked, the stored configuration never moves, and the lock itself never drops. Only the bench's scenarios can show that the turn bits select the right ports for diagonal destinations across many configurations. They also show that the reset word routes correctly and that a write after locking leaves routing unchanged. For this, the bench compares full destination sweeps against an independent model.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  localparam int NUM_MESH = 4;
  localparam int NUM_OUT  = 5;
  localparam int CFG_W    = 12;
  localparam int TURN_W   = 2 * NUM_MESH;

  localparam int P_N   = 0;
  localparam int P_E   = 1;
  localparam int P_W   = 2;
  localparam int P_S   = 3;
  localparam int P_LOC = 4;

  // turn bit pairs: port p owns bits 2p (first cross dir) and 2p+1 (second)
  typedef struct packed {
    logic [TURN_W-1:0]   turn;
    logic [NUM_MESH-1:0] link;
  } routeCfg_t;

  typedef struct packed {
    logic cfgLoad;
    logic locked;
  } ctrlStrobe_t;
endpackage

// File: rtl/route_cfg_ctrl.sv
module route_cfg_ctrl
  import mesh_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        cfgLock,
  output ctrlStrobe_t strb
);
  logic lockQ;

  always_ff @(posedge clk) begin
    if (!rstN)        lockQ <= 1'b0;
    else if (cfgLock) lockQ <= 1'b1;
  end

  always_comb begin
    strb.cfgLoad = cfgWe & ~lockQ;
    strb.locked  = lockQ;
  end

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
endmodule

// File: rtl/route_datapath.sv
module route_datapath
  import mesh_route_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter bit REG_OUT = 1'b0
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  output logic [NUM_OUT-1:0] portReq,
  output logic               routeError
);
  routeCfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN)             cfgQ <= '1;
    else if (strb.cfgLoad) cfgQ <= routeCfg_t'(cfgData);
  end

  logic [NUM_MESH-1:0] dirFlag;
  logic [NUM_MESH-1:0] meshReq;
  logic                isLocal;

  always_comb begin
    dirFlag[P_N] = dstY < curY;
    dirFlag[P_S] = dstY > curY;
    dirFlag[P_E] = dstX > curX;
    dirFlag[P_W] = dstX < curX;
    isLocal      = (dstX == curX) && (dstY == curY);
  end

  for (genvar p = 0; p < NUM_MESH; p++) begin : g_port
    localparam int CA = (p == P_N || p == P_S) ? P_E : P_N;
    localparam int CB = (p == P_N || p == P_S) ? P_W : P_S;
    logic straight, turnA, turnB;
    always_comb begin
      straight   = ~dirFlag[CA] & ~dirFlag[CB];
      turnA      = dirFlag[CA] & cfgQ.turn[2*p];
      turnB      = dirFlag[CB] & cfgQ.turn[2*p+1];
      meshReq[p] = dirFlag[p] & (straight | turnA | turnB) & cfgQ.link[p];
    end
  end

  logic [NUM_OUT-1:0] nextReq;
  logic               nextErr;

  always_comb begin
    nextReq = {isLocal, meshReq};
    nextErr = ~isLocal & ~(|meshReq);
  end

  if (REG_OUT) begin : g_reg
    logic [NUM_OUT-1:0] reqQ;
    logic               errQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqQ <= '0;
        errQ <= 1'b0;
      end else begin
        reqQ <= nextReq;
        errQ <= nextErr;
      end
    end
    assign portReq    = reqQ;
    assign routeError = errQ;
  end else begin : g_comb
    assign portReq    = nextReq;
    assign routeError = nextErr;

    for (genvar c = 0; c < NUM_MESH; c++) begin : g_linkchk
      // R3
      link_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
        !cfgQ.link[c] |-> !portReq[c]);
    end

    // R1
    north_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
      portReq[P_N] |-> (dstY < curY));
  end

  // R4
  local_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    portReq[P_LOC] |-> (portReq[NUM_MESH-1:0] == '0));

  // R5
  err_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeError |-> (portReq == '0));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.locked |=> $stable(cfgQ));
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mesh_route_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter bit REG_OUT = 1'b0
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgLock,
  input  logic [11:0]        cfgData,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  output logic [4:0]         portReq,
  output logic               routeError
);
  ctrlStrobe_t strb;

  route_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgLock (cfgLock),
    .strb    (strb)
  );

  route_datapath #(
    .COORD_W (COORD_W),
    .REG_OUT (REG_OUT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgData    (cfgData),
    .curX       (curX),
    .curY       (curY),
    .dstX       (dstX),
    .dstY       (dstY),
    .portReq    (portReq),
    .routeError (routeError)
  );
endmodule

// File: tb/mesh_route_unit_tb.sv
`timescale 1ns/1ps
module mesh_route_unit_tb;
  localparam int CW = 3;
  localparam int SPAN = 1 << CW;

  logic clk = 1'b0;
  logic rstN, cfgWe, cfgLock;
  logic [11:0] cfgData;
  logic [CW-1:0] curX, curY, dstX, dstY;
  logic [4:0] portReq;
  logic routeError;

  int vecCnt = 0;
  int missCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mesh_route_unit #(.COORD_W(CW), .REG_OUT(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgLock(cfgLock),
    .cfgData(cfgData), .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .portReq(portReq), .routeError(routeError)
  );

  // model from the requirements: returns {err, L, S, W, E, N}
  function automatic logic [5:0] refRoute(input logic [11:0] cfg,
      input int cx, input int cy, input int dx, input int dy);
    bit n, s, e, w;
    bit rn, re, rw, rs, loc;
    n = dy < cy; s = dy > cy; e = dx > cx; w = dx < cx;
    loc = (dx == cx) && (dy == cy);
    rn = n && ((!e && !w) || (e && cfg[4])  || (w && cfg[5]))  && cfg[0];
    re = e && ((!n && !s) || (n && cfg[6])  || (s && cfg[7]))  && cfg[1];
    rw = w && ((!n && !s) || (n && cfg[8])  || (s && cfg[9]))  && cfg[2];
    rs = s && ((!e && !w) || (e && cfg[10]) || (w && cfg[11])) && cfg[3];
    refRoute = {!loc && !(rn || re || rw || rs), loc, rs, rw, re, rn};
  endfunction

  task automatic applyVec(input int cx, input int cy, input int dx, input int dy,
                          input logic [5:0] exp, input string tag);
    @(negedge clk);
    curX = CW'(cx); curY = CW'(cy); dstX = CW'(dx); dstY = CW'(dy);
    #1;
    vecCnt++;
    if ({routeError, portReq} !== exp) begin
      missCnt++;
      $display("FAIL %s cur=(%0d,%0d) dst=(%0d,%0d) got=%b exp=%b",
               tag, cx, cy, dx, dy, {routeError, portReq}, exp);
    end
  endtask

  task automatic sweep(input logic [11:0] cfg, input string tag);
    for (int c = 0; c < 9; c++) begin
      int cx = (c % 3 == 0) ? 0 : (c % 3 == 1) ? 3 : SPAN - 1;
      int cy = (c / 3 == 0) ? 0 : (c / 3 == 1) ? 4 : SPAN - 1;
      for (int d = 0; d < SPAN * SPAN; d++)
        applyVec(cx, cy, d % SPAN, d / SPAN,
                 refRoute(cfg, cx, cy, d % SPAN, d / SPAN), tag);
    end
  endtask

  task automatic writeCfg(input logic [11:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgData = w;
    @(negedge clk);
    cfgWe = 1'b0; cfgData = '0;
  endtask

  task automatic testReset();
    sweep(12'hFFF, "R6");
  endtask

  task automatic testStraight();
    applyVec(3, 3, 3, 1, 6'b000001, "R1 R9 north");
    applyVec(3, 3, 6, 3, 6'b000010, "R1 R9 east");
    applyVec(3, 3, 0, 3, 6'b000100, "R1 R9 west");
    applyVec(3, 3, 3, 7, 6'b001000, "R1 R9 south");
    applyVec(3, 3, 5, 1, 6'b000011, "R1 R9 ne multi");
  endtask

  task automatic testTurns();
    writeCfg(12'h00F);
    applyVec(3, 3, 5, 1, 6'b100000, "R2 no turns");
    sweep(12'h00F, "R2");
    writeCfg(12'h5AF);
    sweep(12'h5AF, "R2 R7");
    writeCfg(12'hA5F);
    sweep(12'hA5F, "R2 R7");
    writeCfg(12'h01F);
    applyVec(3, 3, 5, 1, 6'b000001, "R2 Rne only");
  endtask

  task automatic testLinks();
    writeCfg(12'hFFB);
    applyVec(3, 3, 0, 3, 6'b100000, "R3 west cut");
    applyVec(3, 3, 0, 1, 6'b000001, "R3 west cut diag");
    sweep(12'hFFB, "R3");
    writeCfg(12'h3C6);
    sweep(12'h3C6, "R3");
  endtask

  task automatic testLocal();
    writeCfg(12'h000);
    for (int p = 0; p < SPAN * SPAN; p++)
      applyVec(p % SPAN, p / SPAN, p % SPAN, p / SPAN, 6'b010000, "R4");
  endtask

  task automatic testError();
    writeCfg(12'hFF0);
    applyVec(2, 2, 2, 5, 6'b100000, "R5 no links");
    applyVec(2, 2, 2, 2, 6'b010000, "R5 local not err");
    sweep(12'hFF0, "R5");
  endtask

  task automatic testLock();
    writeCfg(12'h5AF);
    @(negedge clk); cfgLock = 1'b1;
    @(negedge clk); cfgLock = 1'b0;
    writeCfg(12'hFF0);
    applyVec(3, 3, 3, 1, 6'b000001, "R8 write ignored");
    sweep(12'h5AF, "R8");
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgLock = 1'b0; cfgData = '0;
    curX = '0; curY = '0; dstX = '0; dstY = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStraight();
    testTurns();
    testLinks();
    testLocal();
    testError();
    testLock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      missCnt++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end
endmodule